// File: doc/BRIEF.md
# Single-Bit Upset Campaign Controller

This block runs single-event-upset experiments on a small module under test that is built twice inside it: a reference copy and a faulty copy. Both copies advance together under one clock-enable and take the same word from a small stimulus memory on every advance. The host writes this memory and starts experiments with one-cycle command strobes. A campaign run loads an injection cycle T and a bit index L. It resets both copies together and advances them to cycle T. It then flips bit L of the faulty copy while the copies are held, and resumes. It compares the two copies until the primary outputs disagree or a programmable end cycle is reached.

Each run ends with a classification. OUTPUT means the primary outputs differed at some cycle. DAMAGE means that at the end the internal states still differ but no output mismatch was seen. LATENT means the states agree again and no output mismatch was seen. For manual analysis there are four commands: run-to-point stops at cycle T and hands control back, single-step advances both copies by one cycle, inject flips one bit by hand, and diff captures the XOR of the two internal states.

The module under test has three lanes of LANE_W flip-flops, with state bits laid out from the bottom. Bits [LANE_W-1:0] form the output lane, which loads the stimulus word and drives the primary output. Bits [2*LANE_W-1:LANE_W] form the accumulate lane, which XORs the stimulus into itself and is never seen at the output. Bits [3*LANE_W-1:2*LANE_W] form the scratch lane, which loads the inverted stimulus and is never seen at the output.

Top module: `fi_shell`

## Requirements
- R1: After reset: busy=0, done=0, result=0, mis_cycle=0, diff_vec=0, cycle=0, ref_out=0.
- R2: Both copies take the same stimulus. On every advance from cycle count k they read memory word k mod DEPTH. After an advance from k, ref_out equals that word, and the count wraps over the memory.
- R3: busy is high from the edge that takes cmd_run or cmd_goto until the operation ends. done is a one-cycle pulse on the edge where busy falls, and it is never high together with busy.
- R4: With L in the output lane (L < LANE_W), a run returns result 3 (OUTPUT). mis_cycle and the final cycle both equal T, and the run stops at that first mismatch.
- R5: With L in the accumulate lane, a run returns result 2 (DAMAGE), mis_cycle 0, and a diff_vec that has only bit L set.
- R6: With L in the scratch lane, or with L at or above 3*LANE_W (no flip-flop is addressed), a run returns result 1 (LATENT) and diff_vec 0.
- R7: A run that sees no output mismatch ends with cycle equal to max_cycle. If max_cycle is not above T, the run is classified straight after the flip at cycle T, so a scratch-lane flip then reports DAMAGE.
- R8: cmd_goto resets both copies and stops at cycle T with no flip. The two copies then agree (diff gives 0) and result is 0.
- R9: cmd_step while idle advances both copies by exactly one cycle: cycle rises by 1.
- R10: cmd_inject while idle flips bit loc of the faulty copy only, without advancing.
- R11: cmd_diff while idle loads diff_vec with the XOR of the two copies' states. A run also loads diff_vec when it ends.
- R12: mem_we writes mem_wdata to stimulus word mem_addr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_run | input | 1 | Start a full campaign run |
| cmd_goto | input | 1 | Run to cycle T and stop |
| cmd_step | input | 1 | Advance both copies one cycle |
| cmd_inject | input | 1 | Flip bit loc in the faulty copy |
| cmd_diff | input | 1 | Capture the state XOR |
| t_point | input | CW | Injection cycle T |
| loc | input | LW | Bit index L |
| max_cycle | input | CW | Cycle at which a run ends without a mismatch |
| mem_we | input | 1 | Stimulus memory write enable |
| mem_addr | input | AW | Stimulus write address |
| mem_wdata | input | LANE_W | Stimulus write data |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (pulse) |
| result | output | 2 | 0 none, 1 latent, 2 damage, 3 output |
| mis_cycle | output | CW | Cycle of the first output mismatch |
| diff_vec | output | SW | Captured state XOR |
| cycle | output | CW | Advances since the pair reset |
| ref_out | output | LANE_W | Primary output of the reference copy |

## Verification
Campaign runs are tried with flips in each of the three lanes and with an index beyond the last flip-flop, so that the OUTPUT, DAMAGE and LATENT outcomes are each shown to follow from where the bit sits. End cycles below, equal to and above T show whether the end rule is applied before or after the flip has had time to wash out. Manual sequences of goto, step, inject and diff show that a flip in the output lane is overwritten after one step while a flip in the accumulate lane survives it. They also show that a run-to-point past the memory depth reads the wrapped word.

// File: rtl/fi_pkg.sv
package fi_pkg;

    typedef enum logic [1:0] {
        RES_NONE   = 2'd0,
        RES_LATENT = 2'd1,
        RES_DAMAGE = 2'd2,
        RES_OUTPUT = 2'd3
    } fi_res_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PRST,
        ST_ADV,
        ST_FLIP,
        ST_MON
    } fi_st_t;

    localparam int LANES = 3;

    function automatic logic [255:0] bit_mask(input logic [7:0] idx, input int width);
        logic [255:0] m;
        m = '0;
        for (int i = 0; i < 256; i++) begin
            if (i < width && idx == 8'(i)) m[i] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/fi_stim_mem.sv
module fi_stim_mem #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/fi_mut.sv
module fi_mut #(
    parameter int LANE_W = 8,
    localparam int SW    = 3 * LANE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              flip_en,
    input  logic [SW-1:0]     flip_mask,
    input  logic [LANE_W-1:0] din,
    output logic [LANE_W-1:0] dout,
    output logic [SW-1:0]     state_q
);
    logic [SW-1:0] nxt;

    always_comb begin
        nxt[LANE_W-1:0]          = din;
        nxt[2*LANE_W-1:LANE_W]   = state_q[2*LANE_W-1:LANE_W] ^ din;
        nxt[SW-1:2*LANE_W]       = ~din;
    end

    for (genvar g = 0; g < SW; g++) begin : g_ff
        always_ff @(posedge clk) begin
            if (rst)                           state_q[g] <= 1'b0;
            else if (adv)                      state_q[g] <= nxt[g];
            else if (flip_en && flip_mask[g])  state_q[g] <= ~state_q[g];
        end
    end

    assign dout = state_q[LANE_W-1:0];
endmodule

// File: rtl/fi_ctrl.sv
module fi_ctrl
    import fi_pkg::*;
#(
    parameter int CW = 16,
    parameter int LW = 8,
    parameter int SW = 24
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_run,
    input  logic          cmd_goto,
    input  logic          cmd_step,
    input  logic          cmd_inject,
    input  logic          cmd_diff,
    input  logic [CW-1:0] t_point,
    input  logic [CW-1:0] max_cycle,
    input  logic [LW-1:0] loc,
    input  logic          out_mismatch,
    input  logic [SW-1:0] state_xor,
    output logic          busy,
    output logic          done,
    output fi_res_t       result,
    output logic [CW-1:0] mis_cycle,
    output logic [SW-1:0] diff_vec,
    output logic [CW-1:0] cycle,
    output logic          pair_rst,
    output logic          adv,
    output logic          flip_en,
    output logic [LW-1:0] flip_loc
);
    fi_st_t        st;
    logic          full_q;
    logic [CW-1:0] t_q, max_q;
    logic [LW-1:0] loc_q;
    logic          at_t, at_end;

    assign at_t     = (cycle == t_q);
    assign at_end   = (cycle >= max_q);
    assign busy     = (st != ST_IDLE);
    assign pair_rst = (st == ST_PRST);
    assign flip_loc = busy ? loc_q : loc;

    always_comb begin
        adv     = 1'b0;
        flip_en = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (!cmd_run && !cmd_goto) begin
                    adv     = cmd_step;
                    flip_en = !cmd_step && cmd_inject;
                end
            end
            ST_ADV:  adv     = !at_t;
            ST_FLIP: flip_en = 1'b1;
            ST_MON:  adv     = !out_mismatch && !at_end;
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st        <= ST_IDLE;
            full_q    <= 1'b0;
            t_q       <= '0;
            max_q     <= '0;
            loc_q     <= '0;
            done      <= 1'b0;
            result    <= RES_NONE;
            mis_cycle <= '0;
            diff_vec  <= '0;
            cycle     <= '0;
        end else begin
            done <= 1'b0;
            if (adv) cycle <= cycle + 1'b1;
            unique case (st)
                ST_IDLE: begin
                    if (cmd_run || cmd_goto) begin
                        st        <= ST_PRST;
                        full_q    <= cmd_run;
                        t_q       <= t_point;
                        max_q     <= max_cycle;
                        loc_q     <= loc;
                        result    <= RES_NONE;
                        mis_cycle <= '0;
                    end else if (!cmd_step && !cmd_inject && cmd_diff) begin
                        diff_vec <= state_xor;
                    end
                end
                ST_PRST: begin
                    cycle <= '0;
                    st    <= ST_ADV;
                end
                ST_ADV: begin
                    if (at_t) begin
                        if (full_q) begin
                            st <= ST_FLIP;
                        end else begin
                            st   <= ST_IDLE;
                            done <= 1'b1;
                        end
                    end
                end
                ST_FLIP: st <= ST_MON;
                ST_MON: begin
                    if (out_mismatch) begin
                        result    <= RES_OUTPUT;
                        mis_cycle <= cycle;
                        diff_vec  <= state_xor;
                        st        <= ST_IDLE;
                        done      <= 1'b1;
                    end else if (at_end) begin
                        result   <= (state_xor != '0) ? RES_DAMAGE : RES_LATENT;
                        diff_vec <= state_xor;
                        st       <= ST_IDLE;
                        done     <= 1'b1;
                    end
                end
                default: st <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fi_shell.sv
module fi_shell
    import fi_pkg::*;
#(
    parameter int LANE_W = 8,
    parameter int DEPTH  = 16,
    parameter int CW     = 16,
    parameter int LW     = 8,
    localparam int SW    = LANES * LANE_W,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_run,
    input  logic              cmd_goto,
    input  logic              cmd_step,
    input  logic              cmd_inject,
    input  logic              cmd_diff,
    input  logic [CW-1:0]     t_point,
    input  logic [LW-1:0]     loc,
    input  logic [CW-1:0]     max_cycle,
    input  logic              mem_we,
    input  logic [AW-1:0]     mem_addr,
    input  logic [LANE_W-1:0] mem_wdata,
    output logic              busy,
    output logic              done,
    output logic [1:0]        result,
    output logic [CW-1:0]     mis_cycle,
    output logic [SW-1:0]     diff_vec,
    output logic [CW-1:0]     cycle,
    output logic [LANE_W-1:0] ref_out
);
    logic              pair_rst, adv, flip_en;
    logic [LW-1:0]     flip_loc;
    logic [SW-1:0]     mask, ref_st, flt_st;
    logic [LANE_W-1:0] stim, flt_out;
    logic [255:0]      wide_mask;
    fi_res_t           res;

    assign wide_mask = bit_mask(8'(flip_loc), SW);
    assign mask      = wide_mask[SW-1:0];
    assign result    = res;

    fi_stim_mem #(.DEPTH(DEPTH), .DW(LANE_W)) u_mem (
        .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
        .raddr(cycle[AW-1:0]), .rdata(stim)
    );

    fi_mut #(.LANE_W(LANE_W)) u_ref (
        .clk(clk), .rst(rst || pair_rst), .adv(adv), .flip_en(1'b0),
        .flip_mask('0), .din(stim), .dout(ref_out), .state_q(ref_st)
    );

    fi_mut #(.LANE_W(LANE_W)) u_flt (
        .clk(clk), .rst(rst || pair_rst), .adv(adv), .flip_en(flip_en),
        .flip_mask(mask), .din(stim), .dout(flt_out), .state_q(flt_st)
    );

    fi_ctrl #(.CW(CW), .LW(LW), .SW(SW)) u_ctrl (
        .clk(clk), .rst(rst),
        .cmd_run(cmd_run), .cmd_goto(cmd_goto), .cmd_step(cmd_step),
        .cmd_inject(cmd_inject), .cmd_diff(cmd_diff),
        .t_point(t_point), .max_cycle(max_cycle), .loc(loc),
        .out_mismatch(ref_out != flt_out), .state_xor(ref_st ^ flt_st),
        .busy(busy), .done(done), .result(res), .mis_cycle(mis_cycle),
        .diff_vec(diff_vec), .cycle(cycle), .pair_rst(pair_rst),
        .adv(adv), .flip_en(flip_en), .flip_loc(flip_loc)
    );
endmodule

// File: rtl/fi_shell_chk.sv
module fi_shell_chk #(
    parameter int CW = 16,
    parameter int SW = 24
) (
    input logic          clk,
    input logic          rst,
    input logic          cmd_run,
    input logic          cmd_goto,
    input logic          cmd_step,
    input logic          busy,
    input logic          done,
    input logic [1:0]    result,
    input logic [CW-1:0] mis_cycle,
    input logic [SW-1:0] diff_vec,
    input logic [CW-1:0] cycle
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        rst |=> (!busy && !done && cycle == '0));

    assert_done_not_busy_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    assert_busy_fall_done_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    assert_output_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd3) |-> (mis_cycle == cycle));

    assert_damage_diff_R5: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd2) |-> (diff_vec != '0));

    assert_latent_diff_R6: assert property (@(posedge clk) disable iff (rst)
        (done && result == 2'd1) |-> (diff_vec == '0));

    assert_step_one_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_step && !cmd_run && !cmd_goto) |=> (cycle == $past(cycle) + 1'b1));
endmodule

bind fi_shell fi_shell_chk #(.CW(CW), .SW(SW)) u_chk (
    .clk(clk), .rst(rst), .cmd_run(cmd_run), .cmd_goto(cmd_goto),
    .cmd_step(cmd_step), .busy(busy), .done(done), .result(result),
    .mis_cycle(mis_cycle), .diff_vec(diff_vec), .cycle(cycle)
);

// File: tb/sim_fi_shell.sv
module sim_fi_shell;
    localparam int CLK_NS = 10;
    localparam int LANE_W = 8;
    localparam int DEPTH  = 16;
    localparam int CW     = 16;
    localparam int LW     = 8;
    localparam int SW     = 3 * LANE_W;
    localparam int AW     = $clog2(DEPTH);

    typedef struct packed {
        logic [15:0] t;
        logic [7:0]  l;
        logic [15:0] mx;
        logic [1:0]  res;
        logic [15:0] mis;
        logic [15:0] endc;
        logic [23:0] dv;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{16'd5,  8'd3,  16'd40, 2'd3, 16'd5, 16'd5,  24'h000008},
        '{16'd0,  8'd0,  16'd10, 2'd3, 16'd0, 16'd0,  24'h000001},
        '{16'd7,  8'd10, 16'd30, 2'd2, 16'd0, 16'd30, 24'h000400},
        '{16'd2,  8'd15, 16'd20, 2'd2, 16'd0, 16'd20, 24'h008000},
        '{16'd4,  8'd18, 16'd25, 2'd1, 16'd0, 16'd25, 24'h000000},
        '{16'd9,  8'd30, 16'd12, 2'd1, 16'd0, 16'd12, 24'h000000},
        '{16'd6,  8'd20, 16'd6,  2'd2, 16'd0, 16'd6,  24'h100000},
        '{16'd8,  8'd23, 16'd3,  2'd2, 16'd0, 16'd8,  24'h800000},
        '{16'd3,  8'd7,  16'd3,  2'd3, 16'd3, 16'd3,  24'h000080}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cmd_run = 0, cmd_goto = 0, cmd_step = 0, cmd_inject = 0, cmd_diff = 0;
    logic [CW-1:0]     t_point = '0, max_cycle = '0;
    logic [LW-1:0]     loc = '0;
    logic              mem_we = 0;
    logic [AW-1:0]     mem_addr = '0;
    logic [LANE_W-1:0] mem_wdata = '0;
    logic              busy, done;
    logic [1:0]        result;
    logic [CW-1:0]     mis_cycle, cycle;
    logic [SW-1:0]     diff_vec;
    logic [LANE_W-1:0] ref_out;

    int total = 0, bad = 0;
    logic [LANE_W-1:0] stim [DEPTH];

    always #(CLK_NS/2) clk = ~clk;

    fi_shell #(.LANE_W(LANE_W), .DEPTH(DEPTH), .CW(CW), .LW(LW)) u0 (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse(ref logic sig);
        @(negedge clk); sig = 1'b1;
        @(negedge clk); sig = 1'b0;
    endtask

    task automatic wait_done(input string req);
        int n = 0;
        while (!done && n < 2000) begin
            @(negedge clk); n++;
        end
        if (!done) begin
            total++; bad++;
            $display("FAIL %s actual=timeout expected=done", req);
        end
    endtask

    task automatic start(input logic is_run, input logic [15:0] t, input logic [7:0] l,
                         input logic [15:0] mx);
        @(negedge clk);
        t_point = t; loc = l; max_cycle = mx;
        if (is_run) cmd_run = 1'b1; else cmd_goto = 1'b1;
        @(negedge clk);
        cmd_run = 1'b0; cmd_goto = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 150000);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset values
        chk("R1 busy", 32'(busy), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 result", 32'(result), 0);
        chk("R1 mis_cycle", 32'(mis_cycle), 0);
        chk("R1 diff_vec", 32'(diff_vec), 0);
        chk("R1 cycle", 32'(cycle), 0);
        chk("R1 ref_out", 32'(ref_out), 0);
        rst = 1'b0;

        // R12 fill the stimulus memory
        for (int k = 0; k < DEPTH; k++) begin
            stim[k] = LANE_W'(k * 37 + 11);
            @(negedge clk);
            mem_we = 1'b1; mem_addr = AW'(k); mem_wdata = stim[k];
        end
        @(negedge clk); mem_we = 1'b0;

        // Campaign table: R4 output, R5 damage, R6 latent, R7 end rule
        for (int i = 0; i < NV; i++) begin
            start(1'b1, VECS[i].t, VECS[i].l, VECS[i].mx);
            chk("R3 busy during run", 32'(busy), 1);
            wait_done("R3 run finish");
            chk("R3 done without busy", 32'(busy), 0);
            chk("R4 R5 R6 R7 result", 32'(result), 32'(VECS[i].res));
            chk("R4 mis_cycle", 32'(mis_cycle), 32'(VECS[i].mis));
            chk("R7 end cycle", 32'(cycle), 32'(VECS[i].endc));
            chk("R11 run diff", 32'(diff_vec), 32'(VECS[i].dv));
            @(negedge clk);
            chk("R3 done one pulse", 32'(done), 0);
        end

        // R8 run-to-point, R2 stimulus feeding
        start(1'b0, 16'd3, 8'd0, 16'd0);
        wait_done("R8 goto finish");
        chk("R8 stop cycle", 32'(cycle), 3);
        chk("R8 result none", 32'(result), 0);
        chk("R2 ref_out word 2", 32'(ref_out), 32'(stim[2]));
        pulse(cmd_diff);
        chk("R8 no flip", 32'(diff_vec), 0);

        // R9 single step
        pulse(cmd_step);
        chk("R9 cycle+1", 32'(cycle), 4);
        chk("R2 ref_out word 3", 32'(ref_out), 32'(stim[3]));

        // R10 manual inject in output lane, R11 diff
        @(negedge clk); loc = 8'd2;
        pulse(cmd_inject);
        chk("R10 no advance", 32'(cycle), 4);
        pulse(cmd_diff);
        chk("R11 diff after inject", 32'(diff_vec), 32'h4);
        pulse(cmd_step);
        pulse(cmd_diff);
        chk("R11 output lane overwritten", 32'(diff_vec), 0);

        // R10 manual inject in accumulate lane survives a step
        @(negedge clk); loc = 8'd12;
        pulse(cmd_inject);
        pulse(cmd_step);
        pulse(cmd_diff);
        chk("R10 accumulate flip kept", 32'(diff_vec), 32'h1000);

        // R2 wrap over the memory depth
        start(1'b0, 16'd17, 8'd0, 16'd0);
        wait_done("R2 goto wrap");
        chk("R2 wrapped word", 32'(ref_out), 32'(stim[0]));
        pulse(cmd_diff);
        chk("R8 fresh reset clears flip", 32'(diff_vec), 0);

        // R12 rewrite a word, then read it through a goto
        @(negedge clk); mem_we = 1'b1; mem_addr = AW'(5); mem_wdata = 8'hC3;
        @(negedge clk); mem_we = 1'b0;
        start(1'b0, 16'd6, 8'd0, 16'd0);
        wait_done("R12 goto");
        chk("R12 rewritten word", 32'(ref_out), 32'hC3);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule